// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash interface and answers one question: has the program or erase operation that was just launched finished, and did it finish cleanly? After a start pulse it reads the device's 8-bit status word over a simple request/acknowledge read port. It then compares a chosen toggle bit across each pair of consecutive reads. It also watches the device's exceeded-time flag in bit 5.

If the toggle bit holds still, the operation is over. If the bit is still moving while the exceeded-time flag is up, the block runs one more confirming pair of reads, because the toggling may stop at the same moment the flag rises. If that confirming pair still toggles, the block writes the reset command byte through a write request/acknowledge port and reports a failure. A host-side limit on the number of polling pairs guards against a device that never settles. An abort input drops polling at once, and the next start always begins again from a fresh pair of reads.

Top module: `flash_toggle_poller`

## Requirements
- R1: While reset is high and in the cycle after it, busy, done, res_ok, res_fail, res_tmo, rd_req and wr_req are all 0.
- R2: When the selected toggle bit is equal in the first two reads after a start, done and res_ok pulse together in the cycle after the second read's acknowledge, and no write is issued.
- R3: With sel_lo = 0 the toggle bit is bit 6; with sel_lo = 1 it is bit 2. The value is sampled when polling starts. A change in the unselected bit alone does not count as toggling.
- R4: When a pair toggles and bit 5 of the second read of that pair is 0, the block starts a new, independent pair of reads without reporting anything.
- R5: When a pair toggles and bit 5 of its second read is 1, exactly one confirming pair is read. If that pair does not toggle, done and res_ok pulse.
- R6: If the confirming pair still toggles, wr_req rises with wr_data = 8'hF0 and is held until wr_ack. In the cycle after that acknowledge, done and res_fail pulse.
- R7: Each toggling pair with bit 5 = 0 adds one to a pair count. When that count reaches a nonzero poll_limit, done and res_tmo pulse and no further read is requested. A poll_limit of 0 means there is no limit.
- R8: An abort while busy makes busy, rd_req and wr_req 0 in the next cycle and gives no done. The next start begins with two fresh reads.
- R9: busy is 1 from the cycle after an accepted start until the cycle in which done pulses. A start while busy is ignored. A request is held until it is acknowledged, and rd_req and wr_req are never 1 together.
- R10: done is a single-cycle pulse, and exactly one of res_ok, res_fail and res_tmo is 1 with it and only with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (taken when idle) |
| abort | input | 1 | Leave polling immediately |
| sel_lo | input | 1 | 0: watch bit 6, 1: watch bit 2 |
| poll_limit | input | CW | Maximum toggling pairs, 0 = unlimited |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read completed, rd_data valid |
| rd_data | input | DW | Status word returned by the read |
| wr_req | output | 1 | Reset command write request |
| wr_data | output | DW | Command byte (8'hF0 while wr_req) |
| wr_ack | input | 1 | Write completed |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle end-of-poll strobe |
| res_ok | output | 1 | Operation completed |
| res_fail | output | 1 | Operation failed, reset command written |
| res_tmo | output | 1 | Host poll limit reached |

## Verification
The assertions assume that the responder behaves as a well-formed target. This means rd_ack comes only in a cycle where rd_req is high, and wr_ack only where wr_req is high. They also assume that sel_lo and poll_limit do not matter mid-poll, because they are sampled or compared only at defined points. The bench's responder derives each acknowledge from the request level it sees at the falling edge, so it can never acknowledge a request that is not outstanding. Its script of status bytes is consumed one byte per acknowledge, so any extra or missing read shows up as a leftover or an empty script.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FIRST,
    S_SECOND,
    S_CFM_A,
    S_CFM_B,
    S_RSTWR
  } poll_state_t;

  typedef enum logic [1:0] {
    V_NONE,
    V_OK,
    V_FAIL,
    V_TMO
  } verdict_t;
endpackage

// File: rtl/tbp_sample_cmp.sv
module tbp_sample_cmp #(
  parameter int DW = 8,
  parameter int HI_BIT = 6,
  parameter int LO_BIT = 2,
  parameter int FLAG_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          sel_lo,
  input  logic [DW-1:0] data,
  output logic          toggled,
  output logic          flag
);
  // Held copy of both candidate toggle bits from the first read of a pair.
  logic hold_hi;
  logic hold_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_hi <= 1'b0;
      hold_lo <= 1'b0;
    end else if (load) begin
      hold_hi <= data[HI_BIT];
      hold_lo <= data[LO_BIT];
    end
  end

  always_comb begin
    if (sel_lo) toggled = hold_lo ^ data[LO_BIT];
    else        toggled = hold_hi ^ data[HI_BIT];
  end

  assign flag = data[FLAG_BIT];
endmodule

// File: rtl/tbp_pair_count.sv
module tbp_pair_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // True when the pair now being counted would reach the limit.
  always_comb begin
    if (limit == '0) hit = 1'b0;
    else             hit = ({1'b0, cnt} + 1'b1) >= {1'b0, limit};
  end
endmodule

// File: rtl/tbp_result_reg.sv
module tbp_result_reg
  import tbp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  verdict_t fin,
  output logic     done,
  output logic     res_ok,
  output logic     res_fail,
  output logic     res_tmo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      res_ok   <= 1'b0;
      res_fail <= 1'b0;
      res_tmo  <= 1'b0;
    end else begin
      done     <= (fin != V_NONE);
      res_ok   <= (fin == V_OK);
      res_fail <= (fin == V_FAIL);
      res_tmo  <= (fin == V_TMO);
    end
  end
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller
  import tbp_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int HI_BIT = 6,
  parameter int LO_BIT = 2,
  parameter int FLAG_BIT = 5,
  parameter logic [7:0] RESET_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          sel_lo,
  input  logic [CW-1:0] poll_limit,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          busy,
  output logic          done,
  output logic          res_ok,
  output logic          res_fail,
  output logic          res_tmo
);
  localparam logic [DW-1:0] CMD_WORD = DW'(RESET_CMD);

  poll_state_t st, st_n;
  verdict_t    fin;
  logic        ld_first;
  logic        cnt_clr;
  logic        cnt_inc;
  logic        toggled;
  logic        flag;
  logic        cnt_hit;
  logic        sel_q;
  logic        rd_req_q;
  logic        wr_req_q;
  logic        busy_q;

  tbp_sample_cmp #(
    .DW(DW), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT), .FLAG_BIT(FLAG_BIT)
  ) u_cmp (
    .clk(clk), .rst(rst), .load(ld_first), .sel_lo(sel_q),
    .data(rd_data), .toggled(toggled), .flag(flag)
  );

  tbp_pair_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .limit(poll_limit), .hit(cnt_hit)
  );

  tbp_result_reg u_res (
    .clk(clk), .rst(rst), .fin(fin), .done(done),
    .res_ok(res_ok), .res_fail(res_fail), .res_tmo(res_tmo)
  );

  always_comb begin
    st_n     = st;
    fin      = V_NONE;
    ld_first = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (start) begin
          st_n    = S_FIRST;
          cnt_clr = 1'b1;
        end
      end
      S_FIRST: begin
        if (rd_ack) begin
          ld_first = 1'b1;
          st_n     = S_SECOND;
        end
      end
      S_SECOND: begin
        if (rd_ack) begin
          if (!toggled) begin
            fin  = V_OK;
            st_n = S_IDLE;
          end else if (flag) begin
            st_n = S_CFM_A;
          end else begin
            cnt_inc = 1'b1;
            if (cnt_hit) begin
              fin  = V_TMO;
              st_n = S_IDLE;
            end else begin
              st_n = S_FIRST;
            end
          end
        end
      end
      S_CFM_A: begin
        if (rd_ack) begin
          ld_first = 1'b1;
          st_n     = S_CFM_B;
        end
      end
      S_CFM_B: begin
        if (rd_ack) begin
          if (!toggled) begin
            fin  = V_OK;
            st_n = S_IDLE;
          end else begin
            st_n = S_RSTWR;
          end
        end
      end
      S_RSTWR: begin
        if (wr_ack) begin
          fin  = V_FAIL;
          st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (abort && st != S_IDLE) begin
      st_n     = S_IDLE;
      fin      = V_NONE;
      ld_first = 1'b0;
      cnt_inc  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      sel_q    <= 1'b0;
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      st       <= st_n;
      if (st == S_IDLE && start) sel_q <= sel_lo;
      rd_req_q <= (st_n == S_FIRST) || (st_n == S_SECOND) ||
                  (st_n == S_CFM_A) || (st_n == S_CFM_B);
      wr_req_q <= (st_n == S_RSTWR);
      busy_q   <= (st_n != S_IDLE);
    end
  end

  assign rd_req  = rd_req_q;
  assign wr_req  = wr_req_q;
  assign busy    = busy_q;
  assign wr_data = wr_req_q ? CMD_WORD : '0;
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker (
  input logic clk,
  input logic rst,
  input logic abort,
  input logic rd_req,
  input logic rd_ack,
  input logic wr_req,
  input logic wr_ack,
  input logic busy,
  input logic done,
  input logic res_ok,
  input logic res_fail,
  input logic res_tmo
);
  a_r9_req_excl: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_req && !wr_req));

  a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack && !abort) |=> rd_req);

  a_r6_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack && !abort) |=> wr_req);

  a_r10_one_result: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones({res_ok, res_fail, res_tmo}) == 1));

  a_r10_no_stray: assert property (@(posedge clk) disable iff (rst)
    !done |-> !(res_ok || res_fail || res_tmo));

  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> (!busy && !done));

  a_r6_fail_after_write: assert property (@(posedge clk) disable iff (rst)
    $rose(res_fail) |-> $past(wr_req && wr_ack));
endmodule

bind flash_toggle_poller tbp_checker u_tbp_chk (
  .clk(clk), .rst(rst), .abort(abort),
  .rd_req(rd_req), .rd_ack(rd_ack), .wr_req(wr_req), .wr_ack(wr_ack),
  .busy(busy), .done(done), .res_ok(res_ok), .res_fail(res_fail),
  .res_tmo(res_tmo)
);

// File: tb/flash_toggle_poller_bench.sv
module flash_toggle_poller_bench;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          abort = 1'b0;
  logic          sel_lo = 1'b0;
  logic [CW-1:0] poll_limit = '0;
  logic          rd_req;
  logic          rd_ack = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          wr_req;
  logic [DW-1:0] wr_data;
  logic          wr_ack = 1'b0;
  logic          busy, done, res_ok, res_fail, res_tmo;

  flash_toggle_poller #(.DW(DW), .CW(CW)) u_flash_toggle_poller (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .sel_lo(sel_lo),
    .poll_limit(poll_limit), .rd_req(rd_req), .rd_ack(rd_ack),
    .rd_data(rd_data), .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .res_ok(res_ok), .res_fail(res_fail),
    .res_tmo(res_tmo)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string cur_tag = "R1";

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Scripted flash responder.
  logic [7:0] script[$];
  int lat = 0;
  int rwait = 0;
  int wwait = 0;

  // Behavioural reference model.
  bit m_busy, m_rd, m_wr, m_done, m_ok, m_fail, m_tmo, m_sel;
  bit m_have_first, m_confirm;
  logic [7:0] m_first;
  int m_pairs;
  bit m_live = 0;

  function automatic bit watched(input logic [7:0] v, input bit lo);
    return lo ? v[2] : v[6];
  endfunction

  always @(posedge clk) begin
    m_done = 0; m_ok = 0; m_fail = 0; m_tmo = 0;
    if (rst) begin
      m_busy = 0; m_rd = 0; m_wr = 0;
      m_have_first = 0; m_confirm = 0; m_pairs = 0;
    end else if (!m_busy) begin
      if (start) begin
        m_busy = 1; m_rd = 1; m_sel = sel_lo;
        m_have_first = 0; m_confirm = 0; m_pairs = 0;
      end
    end else if (abort) begin
      m_busy = 0; m_rd = 0; m_wr = 0;
    end else if (m_wr) begin
      if (wr_ack) begin
        m_wr = 0; m_busy = 0; m_done = 1; m_fail = 1;
      end
    end else if (rd_ack) begin
      if (!m_have_first) begin
        m_first = rd_data; m_have_first = 1;
      end else begin
        m_have_first = 0;
        if (watched(m_first, m_sel) == watched(rd_data, m_sel)) begin
          m_busy = 0; m_rd = 0; m_done = 1; m_ok = 1;
        end else if (m_confirm) begin
          m_rd = 0; m_wr = 1;
        end else if (rd_data[5]) begin
          m_confirm = 1;
        end else begin
          m_pairs++;
          if (poll_limit != 0 && m_pairs >= int'(poll_limit)) begin
            m_busy = 0; m_rd = 0; m_done = 1; m_tmo = 1;
          end
        end
      end
    end
  end

  int done_cnt = 0;
  int res_code = 0;
  int wr_cycles = 0;

  // Compare, record, then drive responder outputs, all at the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (m_live) begin
      check({cur_tag, " outputs"},
            {busy, rd_req, wr_req, done, res_ok, res_fail, res_tmo} ==
            {m_busy, m_rd, m_wr, m_done, m_ok, m_fail, m_tmo},
            int'({busy, rd_req, wr_req, done, res_ok, res_fail, res_tmo}),
            int'({m_busy, m_rd, m_wr, m_done, m_ok, m_fail, m_tmo}));
      if (wr_req) check("R6 wr_data", wr_data == 8'hF0, int'(wr_data), 8'hF0);
    end
    if (done) begin
      done_cnt++;
      res_code = res_ok ? 1 : res_fail ? 2 : res_tmo ? 3 : 0;
    end
    if (wr_req) wr_cycles++;
    rd_ack = 0;
    if (rd_req) begin
      if (rwait >= lat) begin
        rd_ack = 1;
        rd_data = (script.size() > 0) ? script.pop_front() : 8'h00;
        rwait = 0;
      end else rwait++;
    end else rwait = 0;
    wr_ack = 0;
    if (wr_req) begin
      if (wwait >= 2) begin wr_ack = 1; wwait = 0; end
      else wwait++;
    end else wwait = 0;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic go(input string tag, input bit sel, input int lim, input int lt,
                    input int exp_code, input bit restart_mid);
    cur_tag = tag; sel_lo = sel; poll_limit = CW'(lim); lat = lt;
    done_cnt = 0; res_code = 0; wr_cycles = 0;
    pulse_start();
    if (restart_mid) begin
      repeat (3) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " verdict"}, res_code == exp_code, res_code, exp_code);
    check({tag, " one done"}, done_cnt == 1, done_cnt, 1);
    check({tag, " reads used"}, script.size() == 0, script.size(), 0);
    check({tag, " write iff fail"}, (wr_cycles > 0) == (exp_code == 2),
          wr_cycles, (exp_code == 2) ? 1 : 0);
    script.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, done, res_ok, res_fail, res_tmo, rd_req, wr_req} == 0,
          int'({busy, done, res_ok, res_fail, res_tmo, rd_req, wr_req}), 0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {busy, done, rd_req, wr_req} == 0,
          int'({busy, done, rd_req, wr_req}), 0);
    m_live = 1;

    script = '{8'h40, 8'h40};
    go("R2 stable first pair", 0, 0, 0, 1, 0);
    script = '{8'hC4, 8'h44};
    go("R2 stable bit6 slow ack", 0, 0, 2, 1, 0);

    script = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h44, 8'h44};
    go("R4 new pairs", 0, 8, 1, 1, 0);

    script = '{8'h00, 8'h60, 8'h20, 8'h20};
    go("R5 confirm stable", 0, 0, 0, 1, 0);

    script = '{8'h00, 8'h60, 8'h20, 8'h60};
    go("R6 confirm toggles", 0, 0, 1, 2, 0);

    script = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    go("R7 host limit", 0, 3, 0, 3, 0);
    script.delete();
    for (int i = 0; i < 10; i++) begin script.push_back(8'h00); script.push_back(8'h40); end
    script.push_back(8'h44); script.push_back(8'h44);
    go("R7 limit zero", 0, 0, 0, 1, 0);

    script = '{8'h00, 8'h40};
    go("R3 bit2 ignores bit6", 1, 0, 0, 1, 0);
    script = '{8'h04, 8'h00, 8'h04, 8'h04};
    go("R3 bit2 toggles", 1, 0, 0, 1, 0);
    script = '{8'h04, 8'h40, 8'h00, 8'h00};
    go("R3 bit6 toggles only", 0, 0, 0, 1, 0);

    script = '{8'h00, 8'h40, 8'h44, 8'h44};
    go("R9 start while busy", 0, 0, 2, 1, 1);

    // R8: abort after the first read, then restart fresh.
    cur_tag = "R8 abort"; lat = 3; sel_lo = 0; poll_limit = '0;
    done_cnt = 0; script = '{8'h00};
    pulse_start();
    for (int i = 0; i < 50 && script.size() != 0; i++) @(negedge clk);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    check("R8 idle after abort", {busy, rd_req, wr_req} == 0, int'({busy, rd_req, wr_req}), 0);
    repeat (4) @(negedge clk);
    check("R8 no done on abort", done_cnt == 0, done_cnt, 0);
    script = '{8'h40, 8'h40};
    go("R8 restart fresh", 0, 0, 3, 1, 0);

    // R8: abort during the command write.
    cur_tag = "R8 abort in write"; lat = 0; done_cnt = 0;
    script = '{8'h00, 8'h60, 8'h00, 8'h40};
    pulse_start();
    for (int i = 0; i < 50 && !wr_req; i++) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    check("R8 write dropped", {busy, wr_req} == 0, int'({busy, wr_req}), 0);
    repeat (3) @(negedge clk);
    check("R8 no done after write abort", done_cnt == 0, done_cnt, 0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    total++; bad++;
    $display("FAIL %s watchdog: actual=%0d expected=%0d", cur_tag, cycles, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule